// File: doc/BRIEF.md
# Packed Dual Fractional Halfword Multiplier

This unit multiplies signed 16-bit halfwords two at a time. Each 32-bit operand carries two halfwords. Two products are formed in parallel, and both are packed into one 64-bit result. Word 1 sits in bits 63:32 and always uses the upper halfword of operand A. Word 0 sits in bits 31:0 and always uses the lower halfword of operand A. A 2-bit mode input picks which halfword of operand B feeds each lane.

A one-bit shift control turns on fractional (Q15 inputs, Q31 outputs) operation. With the shift set, each product moves left by one bit. The single case that would overflow, minus one times minus one, is clamped to the largest positive word, and each lane makes that decision on its own. One optional output register, selected by a parameter, sets the latency to one cycle or zero.

Top module: `qmul_pair`

## Requirements
- R1: While the active-low reset is held, and after it is released until the first rising clock edge, `result` reads all zeros (registered build).
- R2: With `REG_OUT`=1, `result` reflects the inputs present at the previous rising clock edge and holds steady between edges when the inputs change.
- R3: When `shiftN`=1 and a lane does not saturate, that lane equals its signed product shifted left by one, so its bit 0 is zero.
- R4: Word 1 (bits 63:32) is the signed product of `opA[31:16]` and the operand-B halfword that the mode selects for lane 1.
- R5: Word 0 (bits 31:0) is the signed product of `opA[15:0]` and the operand-B halfword that the mode selects for lane 0.
- R6: The mode encoding selects the operand-B halfwords, listed here as (lane 1, lane 0). 0 selects (upper, upper). 1 selects (lower, upper). 2 selects (lower, lower). 3 selects (upper, lower).
- R7: A lane whose two selected halfwords are both 8000h, with `shiftN`=1, yields 7FFFFFFFh.
- R8: With `shiftN`=0 there is no saturation: 8000h times 8000h yields 40000000h, and no lane ever reads 7FFFFFFFh.
- R9: Saturation is decided per lane, so one lane can saturate while the other returns its ordinary shifted product.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| opA | input | 32 | Operand A, two signed halfwords |
| opB | input | 32 | Operand B, two signed halfwords |
| mode | input | 2 | Operand-B halfword selection per lane (see R6) |
| shiftN | input | 1 | Fractional left shift by one, with saturation enabled |
| result | output | 64 | Packed products, word 1 high and word 0 low |

## Verification
The bench builds the unit with 16-bit halfwords and `REG_OUT`=1. This build brings the one-cycle latency and the reset value of the output register within reach, and it makes the 8000h corner reachable with ordinary random patterns that are biased toward that value. Seeded random operands sweep all four modes and both shift settings. Directed vectors with small distinct halfwords separate each mode's selection. Further directed vectors saturate one lane alone, then the other, then both, and repeat the same corners with the shift off.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
  localparam int LANES = 2;

  typedef enum logic [1:0] {
    MODE_UU = 2'd0,
    MODE_LU = 2'd1,
    MODE_LL = 2'd2,
    MODE_UL = 2'd3
  } qmode_e;

  typedef struct packed {
    logic [LANES-1:0] bUpper;   // per lane: take the upper half of operand B
    logic             shiftOne; // fractional shift and saturation enable
  } qctrl_t;
endpackage

// File: rtl/qmul_ctrl.sv
module qmul_ctrl
  import qmul_pkg::*;
(
  input  logic [1:0] mode,
  input  logic       shiftN,
  output qctrl_t     ctrl
);
  qmode_e modeSel;

  always_comb begin
    modeSel = qmode_e'(mode);
    ctrl.shiftOne = shiftN;
    // lane 1 takes B upper in UU and UL; lane 0 takes B upper in UU and LU
    ctrl.bUpper[1] = (modeSel == MODE_UU) || (modeSel == MODE_UL);
    ctrl.bUpper[0] = (modeSel == MODE_UU) || (modeSel == MODE_LU);
  end
endmodule

// File: rtl/qmul_lane.sv
module qmul_lane #(
  parameter int HALF_W = 16
) (
  input  logic [HALF_W-1:0]   aHalf,
  input  logic [HALF_W-1:0]   bHalf,
  input  logic                shiftOne,
  output logic [2*HALF_W-1:0] word
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] MIN_HALF = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] MAX_WORD = {1'b0, {(WORD_W-1){1'b1}}};

  logic signed [WORD_W-1:0] prod;
  logic                     satHit;

  always_comb begin
    prod   = $signed(aHalf) * $signed(bHalf);
    satHit = shiftOne && (aHalf == MIN_HALF) && (bHalf == MIN_HALF);
    if (satHit)
      word = MAX_WORD;
    else if (shiftOne)
      word = {prod[WORD_W-2:0], 1'b0};
    else
      word = prod;
  end
endmodule

// File: rtl/qmul_dp.sv
module qmul_dp
  import qmul_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0]       opA,
  input  logic [2*HALF_W-1:0]       opB,
  input  qctrl_t                    ctrl,
  output logic [LANES*2*HALF_W-1:0] packed_out
);
  localparam int WORD_W = 2 * HALF_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [HALF_W-1:0] bPick;
    logic [WORD_W-1:0] laneWord;

    assign bPick = ctrl.bUpper[i] ? opB[HALF_W +: HALF_W] : opB[0 +: HALF_W];

    qmul_lane #(.HALF_W(HALF_W)) u_lane (
      .aHalf    (opA[i*HALF_W +: HALF_W]),
      .bHalf    (bPick),
      .shiftOne (ctrl.shiftOne),
      .word     (laneWord)
    );

    assign packed_out[i*WORD_W +: WORD_W] = laneWord;
  end
endmodule

// File: rtl/qmul_pair.sv
module qmul_pair
  import qmul_pkg::*;
#(
  parameter int HALF_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*HALF_W-1:0]   opA,
  input  logic [2*HALF_W-1:0]   opB,
  input  logic [1:0]            mode,
  input  logic                  shiftN,
  output logic [4*HALF_W-1:0]   result
);
  localparam int RES_W = 4 * HALF_W;

  qctrl_t           ctrl;
  logic [RES_W-1:0] dpOut;

  qmul_ctrl u_ctrl (
    .mode   (mode),
    .shiftN (shiftN),
    .ctrl   (ctrl)
  );

  qmul_dp #(.HALF_W(HALF_W)) u_dp (
    .opA        (opA),
    .opB        (opB),
    .ctrl       (ctrl),
    .packed_out (dpOut)
  );

  if (REG_OUT) begin : g_reg
    logic [RES_W-1:0] resultQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) resultQ <= '0;
      else        resultQ <= dpOut;
    end
    assign result = resultQ;
  end else begin : g_comb
    assign result = dpOut;
  end
endmodule

// File: rtl/qmul_pair_chk.sv
module qmul_pair_chk #(
  parameter int HALF_W  = 16,
  parameter bit REG_OUT = 1'b1
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2*HALF_W-1:0] opA,
  input logic [2*HALF_W-1:0] opB,
  input logic [1:0]          mode,
  input logic                shiftN,
  input logic [4*HALF_W-1:0] result
);
  localparam int WORD_W = 2 * HALF_W;
  localparam logic [HALF_W-1:0] MIN_HALF = {1'b1, {(HALF_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] MAX_WORD = {1'b0, {(WORD_W-1){1'b1}}};

  logic [WORD_W-1:0] pA, pB;
  logic [1:0]        pMode;
  logic              pN, pOk;

  if (REG_OUT) begin : g_lat1
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pA <= '0; pB <= '0; pMode <= '0; pN <= 1'b0; pOk <= 1'b0;
      end else begin
        pA <= opA; pB <= opB; pMode <= mode; pN <= shiftN; pOk <= 1'b1;
      end
    end
  end else begin : g_lat0
    assign pA = opA;
    assign pB = opB;
    assign pMode = mode;
    assign pN = shiftN;
    assign pOk = 1'b1;
  end

  logic [HALF_W-1:0] b1Sel, b0Sel;
  assign b1Sel = (pMode == 2'd0 || pMode == 2'd3) ? pB[WORD_W-1:HALF_W] : pB[HALF_W-1:0];
  assign b0Sel = (pMode == 2'd0 || pMode == 2'd1) ? pB[WORD_W-1:HALF_W] : pB[HALF_W-1:0];

  // R7, R9: each lane saturates on its own corner
  assert_sat_word1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pOk && pN && pA[WORD_W-1:HALF_W] == MIN_HALF && b1Sel == MIN_HALF)
      |-> result[2*WORD_W-1:WORD_W] == MAX_WORD);
  assert_sat_word0_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pOk && pN && pA[HALF_W-1:0] == MIN_HALF && b0Sel == MIN_HALF)
      |-> result[WORD_W-1:0] == MAX_WORD);
  // R8: no saturation value without the shift
  assert_no_sat_unshifted_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pOk && !pN) |-> (result[2*WORD_W-1:WORD_W] != MAX_WORD && result[WORD_W-1:0] != MAX_WORD));
  // R3: shifted, unsaturated lane has a zero LSB
  assert_shift_lsb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pOk && pN && result[WORD_W-1:0] != MAX_WORD) |-> result[0] == 1'b0);
  // R4: zero A-upper gives zero word 1
  assert_word1_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pOk && pA[WORD_W-1:HALF_W] == '0) |-> result[2*WORD_W-1:WORD_W] == '0);
  // R5: zero selected B half gives zero word 0
  assert_word0_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pOk && b0Sel == '0) |-> result[WORD_W-1:0] == '0);
endmodule

bind qmul_pair qmul_pair_chk #(.HALF_W(HALF_W), .REG_OUT(REG_OUT)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .opA    (opA),
  .opB    (opB),
  .mode   (mode),
  .shiftN (shiftN),
  .result (result)
);

// File: tb/qmul_pair_tb.sv
`timescale 1ns/1ps
module qmul_pair_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic [1:0]  mode = '0;
  logic        shiftN = 1'b0;
  logic [63:0] result;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  qmul_pair #(.HALF_W(16), .REG_OUT(1'b1)) u_dut (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB),
    .mode(mode), .shiftN(shiftN), .result(result)
  );

  function automatic logic [31:0] laneRef(logic [15:0] x, logic [15:0] y, logic n);
    logic signed [31:0] p;
    if (n && x == 16'h8000 && y == 16'h8000) return 32'h7FFF_FFFF;
    p = $signed({{16{x[15]}}, x}) * $signed({{16{y[15]}}, y});
    return n ? {p[30:0], 1'b0} : p;
  endfunction

  function automatic logic [63:0] pairRef(logic [31:0] a, logic [31:0] b, logic [1:0] m, logic n);
    logic [15:0] b1, b0;
    case (m)
      2'd0: begin b1 = b[31:16]; b0 = b[31:16]; end
      2'd1: begin b1 = b[15:0];  b0 = b[31:16]; end
      2'd2: begin b1 = b[15:0];  b0 = b[15:0];  end
      default: begin b1 = b[31:16]; b0 = b[15:0]; end
    endcase
    return {laneRef(a[31:16], b1, n), laneRef(a[15:0], b0, n)};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, sample 1 ns after the next rising edge
  task automatic apply(logic [31:0] a, logic [31:0] b, logic [1:0] m, logic n);
    @(negedge clk);
    opA = a; opB = b; mode = m; shiftN = n;
    @(posedge clk);
    #1;
  endtask

  task automatic run(string tag, logic [31:0] a, logic [31:0] b, logic [1:0] m, logic n,
                     logic [63:0] exp);
    apply(a, b, m, n);
    check(tag, result, exp);
  endtask

  function automatic logic [15:0] pickHalf();
    logic [3:0] r = 4'($urandom);
    return (r < 4'd3) ? 16'h8000 : 16'($urandom);
  endfunction

  initial begin
    void'($urandom(32'h00C0FFEE));
    opA = 32'hFFFF_FFFF; opB = 32'h8000_8000; shiftN = 1'b1;
    #7;
    check("R1 reset hold", result, 64'h0);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R1 after release", result, 64'h0);

    // R6 mode selection with distinct small halves: A=(3,5), B=(7,11)
    run("R6 mode UU", 32'h0003_0005, 32'h0007_000B, 2'd0, 1'b0, {32'd21, 32'd35});
    run("R6 mode LU", 32'h0003_0005, 32'h0007_000B, 2'd1, 1'b0, {32'd33, 32'd35});
    run("R6 mode LL", 32'h0003_0005, 32'h0007_000B, 2'd2, 1'b0, {32'd33, 32'd55});
    run("R6 mode UL", 32'h0003_0005, 32'h0007_000B, 2'd3, 1'b0, {32'd21, 32'd55});
    // R4 R5 signed products
    run("R4 R5 signed", 32'hFFFE_0004, 32'hFFFD_0002, 2'd3, 1'b0, {32'd6, 32'd8});
    run("R3 shift", 32'hFFFE_0004, 32'hFFFD_0002, 2'd3, 1'b1, {32'd12, 32'd16});
    // R7 both lanes saturate
    run("R7 both sat", 32'h8000_8000, 32'h8000_8000, 2'd2, 1'b1, 64'h7FFF_FFFF_7FFF_FFFF);
    // R8 no saturation without shift
    run("R8 unshifted corner", 32'h8000_8000, 32'h8000_8000, 2'd0, 1'b0, 64'h4000_0000_4000_0000);
    // R9 lane 1 alone
    run("R9 lane1 only", 32'h8000_0001, 32'h1234_8000, 2'd2, 1'b1, 64'h7FFF_FFFF_FFFF_0000);
    // R9 lane 0 alone (mode LU: lane0 uses B upper)
    run("R9 lane0 only", 32'h0002_8000, 32'h8000_0003, 2'd1, 1'b1, 64'h0000_000C_7FFF_FFFF);

    // R2 output holds between edges after inputs change
    @(negedge clk);
    opA = 32'h0001_0001; opB = 32'h0001_0001; mode = 2'd2; shiftN = 1'b0;
    #1;
    check("R2 hold before edge", result, 64'h0000_000C_7FFF_FFFF);
    @(posedge clk);
    #1;
    check("R2 update after edge", result, 64'h0000_0001_0000_0001);

    // random sweep across modes and shift
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      logic [1:0]  m;
      logic        n;
      a = {pickHalf(), pickHalf()};
      b = {pickHalf(), pickHalf()};
      m = 2'(i);
      n = 1'($urandom);
      run("R4 R5 R7 random", a, b, m, n, pairRef(a, b, m, n));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule